// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts clock cycles and selected hardware events for profiling. It has one cycle counter and two event counters, all 32 bits wide. One packed control word holds everything that steers them: a global run bit, self-clearing counter resets, a divide-by-64 mode for the cycle counter, per-counter interrupt enables, sticky overflow flags and an 8-bit event code for each event counter. Each event code picks one line from an input vector of single-cycle event pulses. The code 0xFF parks a counter.

Software uses a four-word register port. Address 0 is the control word, address 1 is the cycle counter, address 2 is event counter 0 and address 3 is event counter 1. Writes take effect on the clock edge, and reads are combinational. The overflow flags are cleared by writing ones to them, so writing back a control value that was just read acknowledges every overflow it shows. The interrupt output is a level. It stays high while any flag is set whose interrupt enable is also set.

Top module: `perf_monitor`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Control layout: bit 0 is run, bit 3 is divide-by-64, bits 6:4 are the interrupt enables (event 0, event 1, cycle), bits 10:8 are the overflow flags in the same counter order, bits 19:12 are event code 0 and bits 27:20 are event code 1. Bits 1, 2, 7, 11 and 31:28 always read zero.
- R3: While run is 0, no counter changes except through a direct write or a reset bit.
- R4: With run set and divide mode off, the cycle counter adds one on every clock.
- R5: In divide mode, with the prescaler restarted by a cycle reset, the cycle counter adds one on the 64th clock after the restart and not before.
- R6: An event counter adds one on each clock where run is set and the input line indexed by its code is high. Code 0xFF never counts.
- R7: Addresses 1, 2 and 3 each load and read back their own counter.
- R8: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter and its prescaler. Neither changes the overflow flags.
- R9: A counter that steps from all ones to zero sets its overflow flag.
- R10: Writing 1 to a flag clears it. A flag set by a wrap on the same edge as a clearing write stays set.
- R11: `irq` is high exactly when some overflow flag and its interrupt enable are both set.
- R12: Each flag is independent: a wrap on one counter, or clearing one flag, leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | NUM_EVT | Event pulse lines, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
A register write lands on the edge that samples it, and reads are combinational. The bench therefore drives on the falling edge and reads at the next falling edge, half a cycle after the write. Counting follows the registered run and code values, so it starts on the edge after the control write. The cycle counter's value is checked exactly N falling edges after the write that loaded it, and in divide mode at edges 63 and 64 after the restart. Event counts are set by holding a line high for a known number of falling-edge intervals. Flags and `irq` are sampled at the falling edge right after the wrap edge, and the same-edge set and clear case is driven inside a single write cycle.

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int CNT_W         = 32,
  parameter int NUM_EVT       = 32,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CYC  = 2'd1;
  localparam logic [1:0] A_EV0  = 2'd2;
  localparam logic [1:0] A_EV1  = 2'd3;
  localparam logic [7:0] PARK   = 8'hFF;

  // index 0: event counter 0, 1: event counter 1, 2: cycle counter
  logic             run, slow;
  logic [2:0]       ie, ovf, inc, ld, clr, wrap;
  logic [7:0]       sel0, sel1;
  logic [CNT_W-1:0] cnt [3];
  logic [PRESCALE_LOG2-1:0] pre;
  logic [255:0]     evt_ext;
  logic             unused_bits;

  wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
  wire clr_ev  = wr_ctrl && reg_wdata[1];
  wire clr_cyc = wr_ctrl && reg_wdata[2];
  wire tick    = run && (!slow || (&pre));

  assign evt_ext     = 256'(evt_in);
  assign unused_bits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

  assign inc[0] = run && (sel0 != PARK) && evt_ext[sel0];
  assign inc[1] = run && (sel1 != PARK) && evt_ext[sel1];
  assign inc[2] = tick;
  assign ld  = {reg_we && reg_addr == A_CYC, reg_we && reg_addr == A_EV1,
                reg_we && reg_addr == A_EV0};
  assign clr = {clr_cyc, clr_ev, clr_ev};

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    assign wrap[k] = inc[k] && !clr[k] && !ld[k] && (&cnt[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[k] <= '0;
      else if (clr[k]) cnt[k] <= '0;
      else if (ld[k])  cnt[k] <= reg_wdata[CNT_W-1:0];
      else if (inc[k]) cnt[k] <= cnt[k] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (clr_cyc)       pre <= '0;
    else if (run && slow)   pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; slow <= 1'b0; ie <= '0; ovf <= '0;
      sel0 <= '0; sel1 <= '0;
    end else begin
      if (wr_ctrl) begin
        run  <= reg_wdata[0];
        slow <= reg_wdata[3];
        ie   <= reg_wdata[6:4];
        sel0 <= reg_wdata[19:12];
        sel1 <= reg_wdata[27:20];
        ovf  <= (ovf & ~reg_wdata[10:8]) | wrap;
      end else begin
        ovf  <= ovf | wrap;
      end
    end
  end

  assign irq = |(ovf & ie);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {4'b0, sel1, sel0, 1'b0, ovf, 1'b0, ie, slow, 2'b0, run};
      A_CYC:   reg_rdata = 32'(cnt[2]);
      A_EV0:   reg_rdata = 32'(cnt[0]);
      default: reg_rdata = 32'(cnt[1]);
    endcase
  end

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reg_we |=> $stable(cnt[0]) && $stable(cnt[1]) && $stable(cnt[2]));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !slow && !reg_we |=> cnt[2] == $past(cnt[2]) + 1'b1);
  a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
    sel0 == PARK && !reg_we |=> $stable(cnt[0]));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev && ovf[0] && !reg_wdata[8] |=> cnt[0] == '0 && cnt[1] == '0 && ovf[0]);
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt[2]) && tick && !reg_we |=> ovf[2] && cnt[2] == '0);
  a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf));
  a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] && !(wr_ctrl && reg_wdata[8]) |=> ovf[0]);
endmodule

// File: tb/perf_monitor_bench.sv
`timescale 1ns/1ps
module perf_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_in = '0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_monitor u_perf_monitor (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  // {is_write, addr, data}; reads carry the expected value
  localparam logic [34:0] TBL [13] = '{
    {1'b1, 2'd0, 32'hFFFF_FFF6}, {1'b0, 2'd0, 32'h0FFF_F070},
    {1'b1, 2'd0, 32'h0000_0000}, {1'b0, 2'd0, 32'h0000_0000},
    {1'b1, 2'd1, 32'h1234_5678}, {1'b0, 2'd1, 32'h1234_5678},
    {1'b1, 2'd2, 32'hDEAD_BEEF}, {1'b0, 2'd2, 32'hDEAD_BEEF},
    {1'b1, 2'd3, 32'hA5A5_A5A5}, {1'b0, 2'd3, 32'hA5A5_A5A5},
    {1'b1, 2'd0, 32'h0000_0888}, {1'b0, 2'd0, 32'h0000_0008},
    {1'b1, 2'd0, 32'h0000_0000}};

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.1;
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(0, 0, "R1"); rd_chk(1, 0, "R1"); rd_chk(2, 0, "R1"); rd_chk(3, 0, "R1");
    irq_chk(1'b0, "R1");

    for (int i = 0; i < 13; i++) begin
      if (TBL[i][34]) wr(TBL[i][33:32], TBL[i][31:0]);
      else rd_chk(TBL[i][33:32], TBL[i][31:0], TBL[i][33:32] == 2'd0 ? "R2" : "R7");
    end

    // R3: stopped, lines active
    evt_in = '1;
    repeat (10) @(negedge clk);
    evt_in = '0;
    rd_chk(1, 32'h1234_5678, "R3"); rd_chk(2, 32'hDEAD_BEEF, "R3");

    // R4
    wr(0, 32'h1); wr(1, 32'd100);
    repeat (10) @(negedge clk);
    rd_chk(1, 32'd110, "R4");

    // R5: divide mode with prescaler restart
    wr(0, 32'hD);
    repeat (63) @(negedge clk);
    rd_chk(1, 32'd0, "R5");
    @(negedge clk);
    rd_chk(1, 32'd1, "R5");

    // R6: code 5 on counter 0, counter 1 parked, event counters cleared
    wr(0, 32'h0FF0_5003);
    evt_in = '1;
    repeat (3) @(negedge clk);
    evt_in = '0;
    rd_chk(2, 32'd3, "R6"); rd_chk(3, 32'd0, "R6");
    wr(0, 32'h0070_5001);
    evt_in = 32'h80;
    repeat (2) @(negedge clk);
    evt_in = '0;
    rd_chk(2, 32'd3, "R6"); rd_chk(3, 32'd2, "R6");

    // R9 / R11: event counter 0 wraps
    wr(0, 32'h0070_5011);
    wr(2, 32'hFFFF_FFFE);
    evt_in = 32'h20;
    repeat (2) @(negedge clk);
    evt_in = '0;
    rd_chk(2, 32'd0, "R9"); rd_chk(0, 32'h0070_5111, "R9");
    irq_chk(1'b1, "R11");

    // R12: cycle wrap leaves flag 0 alone; clearing flag 0 leaves flag 2
    wr(1, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk(0, 32'h0070_5511, "R12");
    wr(0, 32'h0070_5111);
    rd_chk(0, 32'h0070_5411, "R12");
    irq_chk(1'b0, "R11");

    // R10: write-back acknowledges
    wr(0, 32'h0070_5411);
    rd_chk(0, 32'h0070_5011, "R10");

    // R8: resets keep flags
    wr(2, 32'hFFFF_FFFF);
    evt_in = 32'h20;
    @(negedge clk);
    evt_in = '0;
    wr(0, 32'h0070_5017);
    rd_chk(0, 32'h0070_5111, "R8");
    rd_chk(2, 32'd0, "R8"); rd_chk(3, 32'd0, "R8"); rd_chk(1, 32'd0, "R8");

    // R10: wrap on the clearing edge keeps the flag
    wr(2, 32'hFFFF_FFFF);
    evt_in = 32'h20;
    wr(0, 32'h0070_5111);
    evt_in = '0;
    rd_chk(0, 32'h0070_5111, "R10");
    irq_chk(1'b1, "R11");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule